// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable behavioural model of a single-port SRAM with one shared data bus and four byte lanes. Every control input, the address and the write data are taken at the rising clock edge. Read data leaves through an output register, so the word for an accepted address appears one edge later. A new read address can be accepted on every edge.

An access begins on one of two active-low address strobes. The processor strobe gives a write that takes two cycles: the strobe cycle only captures the address, and the write happens at the following edge. The controller strobe gives a write that finishes at the edge where it is presented. A two-bit wrapping sequencer steps through a four-word group in linear or interleaved order while the advance input is low. The bidirectional bus is split into an input port, an output port and a driver enable. The enable is forced low after a write, after a deselect, and in the first cycle after reselection. An asynchronous output enable gates it without any register.

Top module: `burst_sram`

## Requirements
- R1: A read accepted at clock edge N drives the addressed word on `dq_o` with `dq_oe` high after edge N+1, provided `oe_n` is low and edge N+1 carries no write or deselect. Reads to different addresses on consecutive edges are each returned one edge later.
- R2: A read starts when an address strobe is active, the selects are active (`sel1_n`=0, `sel2`=1, `sel3_n`=0), and both `glob_wr_n` and `byte_wr_n` are high. The value of `lane_sel_n` then has no effect and the memory is left unchanged.
- R3: A low `strobe_proc_n` is ignored while `sel1_n` is high. When deselected it starts nothing. When selected the current access continues at its present address.
- R4: A processor-strobe access captures the address and ignores the write controls, the data and `advance_n` on its first edge. A write on the next edge then uses the controls and data sampled at that edge.
- R5: A controller-strobe write completes at its own edge. It needs `strobe_proc_n` high, since both strobes low together start a processor-strobe access whose write controls are ignored.
- R6: With `glob_wr_n` low, all four lanes are written, whatever `byte_wr_n` and `lane_sel_n` hold.
- R7: With `glob_wr_n` high and `byte_wr_n` low, only lanes whose `lane_sel_n` bit is 0 are written. Bit i controls data bits 8i+7..8i. The other lanes keep their contents.
- R8: On the edge that starts an access from the deselected state, `dq_oe` is low afterwards, even with `oe_n` low.
- R9: An edge with an accepted strobe and inactive selects deselects the device. `dq_oe` is low right after that edge, and no access continues until a new start.
- R10: After any edge that performs a write, `dq_oe` is low regardless of `oe_n`.
- R11: `oe_n` high forces `dq_oe` low combinationally, and lowering it restores the drive without a clock edge.
- R12: While selected with no strobe, `advance_n` low steps the two low address bits before the access. The order is linear (start+k mod 4) when `burst_order_i` was 0 at the start, or interleaved (start XOR k) when it was 1. The upper bits stay unchanged.
- R13: After reset, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW (6) | Word address |
| burst_order_i | input | 1 | Burst order taken at a start: 0 linear, 1 interleaved |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 32 | Write data from the bus |
| dq_o | output | 32 | Registered read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The hardest case to reach is the two-cycle processor-strobe write. Its first edge must discard write controls that would otherwise be legal. So the bench presents a global write with junk data on the strobe edge, then a single-lane byte write on the next edge, and reads the word back to show that only that one lane changed. A second hard case is a processor strobe hidden by a high first select while an access is running. It is reached by holding a continuing read and showing that the returned word stays at the old address rather than the one on the pins.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } op_e;

    // offset within the burst group after 'step' advances
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  interleave
    );
        logic [BURST_BITS-1:0] sum;
        sum = start + step;
        return interleave ? (start ^ step) : sum;
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_addr,
    input  logic          order_i,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr
);
    localparam int BB = BURST_BITS;

    logic [AW-1:0] base_q;
    logic [BB-1:0] count_q;
    logic [BB-1:0] count_nx;
    logic          order_q;

    assign count_nx = count_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            count_q <= '0;
            order_q <= 1'b0;
        end else if (load) begin
            base_q  <= load_addr;
            count_q <= '0;
            order_q <= order_i;
        end else if (step) begin
            count_q <= count_nx;
        end
    end

    assign cur_addr  = {base_q[AW-1:BB], burst_offset(base_q[BB-1:0], count_q, order_q)};
    assign next_addr = {base_q[AW-1:BB], burst_offset(base_q[BB-1:0], count_nx, order_q)};

endmodule

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
    import sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_i,
    input  logic [AW-1:0]    cur_addr,
    input  logic [AW-1:0]    next_addr,
    input  logic             strobe_proc_n,
    input  logic             strobe_ctrl_n,
    input  logic             advance_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             glob_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output op_e              op,
    output logic [AW-1:0]    op_addr,
    output logic [LANES-1:0] wr_mask,
    output logic             load,
    output logic             step,
    output logic             selected
);
    logic sel_ok;
    logic proc_hit;
    logic ctrl_hit;
    logic wr_req;
    logic selected_q;

    assign sel_ok   = !sel1_n && sel2 && !sel3_n;
    // processor strobe only counts while the first select is active
    assign proc_hit = !strobe_proc_n && !sel1_n;
    assign ctrl_hit = !strobe_ctrl_n;
    assign wr_req   = !glob_wr_n || !byte_wr_n;
    // global write wins over the per-lane controls
    assign wr_mask  = !glob_wr_n ? {LANES{1'b1}} :
                      (!byte_wr_n ? ~lane_sel_n : {LANES{1'b0}});

    always_comb begin
        op      = OP_IDLE;
        op_addr = cur_addr;
        load    = 1'b0;
        step    = 1'b0;
        if ((proc_hit || ctrl_hit) && !sel_ok) begin
            op = OP_DESEL;
        end else if (proc_hit) begin
            // first cycle: write controls and advance are not looked at
            op      = OP_READ;
            op_addr = addr_i;
            load    = 1'b1;
        end else if (ctrl_hit) begin
            op      = wr_req ? OP_WRITE : OP_READ;
            op_addr = addr_i;
            load    = 1'b1;
        end else if (selected_q) begin
            step    = !advance_n;
            op_addr = !advance_n ? next_addr : cur_addr;
            op      = wr_req ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            selected_q <= 1'b0;
        end else if (op == OP_DESEL) begin
            selected_q <= 1'b0;
        end else if (load) begin
            selected_q <= 1'b1;
        end
    end

    assign selected = selected_q;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) begin
                cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          oe_n,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    logic          pending_q;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] dq_q;
    logic          drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            rd_addr_q <= '0;
            dq_q      <= '0;
            drive_q   <= 1'b0;
        end else begin
            pending_q <= (op == OP_READ);
            if (op == OP_READ) begin
                rd_addr_q <= op_addr;
            end
            if (pending_q) begin
                dq_q <= rd_data;
            end
            drive_q <= pending_q && (op != OP_WRITE) && (op != OP_DESEL);
        end
    end

    assign rd_addr = rd_addr_q;
    assign dq_o    = dq_q;
    assign dq_oe   = drive_q && !oe_n;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr_i,
    input  logic                    burst_order_i,
    input  logic                    strobe_proc_n,
    input  logic                    strobe_ctrl_n,
    input  logic                    advance_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    glob_wr_n,
    input  logic                    byte_wr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    localparam int DW = LANES * LANE_W;

    op_e              op;
    logic [AW-1:0]    op_addr;
    logic [LANES-1:0] wr_mask;
    logic             seq_load;
    logic             seq_step;
    logic             selected;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    next_addr;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_data;

    sram_burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (seq_load),
        .step      (seq_step),
        .load_addr (addr_i),
        .order_i   (burst_order_i),
        .cur_addr  (cur_addr),
        .next_addr (next_addr)
    );

    sram_access_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
        .clk           (clk),
        .rst           (rst),
        .addr_i        (addr_i),
        .cur_addr      (cur_addr),
        .next_addr     (next_addr),
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .advance_n     (advance_n),
        .sel1_n        (sel1_n),
        .sel2          (sel2),
        .sel3_n        (sel3_n),
        .glob_wr_n     (glob_wr_n),
        .byte_wr_n     (byte_wr_n),
        .lane_sel_n    (lane_sel_n),
        .op            (op),
        .op_addr       (op_addr),
        .wr_mask       (wr_mask),
        .load          (seq_load),
        .step          (seq_step),
        .selected      (selected)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (op == OP_WRITE),
        .wr_addr (op_addr),
        .wr_mask (wr_mask),
        .wr_data (dq_i),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sram_out_stage #(.AW(AW), .DW(DW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .op_addr (op_addr),
        .rd_data (rd_data),
        .oe_n    (oe_n),
        .rd_addr (rd_addr),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic strobe_proc_n,
    input logic strobe_ctrl_n,
    input logic sel1_n,
    input logic sel2,
    input logic sel3_n,
    input logic glob_wr_n,
    input logic byte_wr_n,
    input logic oe_n,
    input logic dq_oe,
    input logic selected
);
    logic sel_ok;
    logic proc_hit;
    logic any_hit;
    logic wr_req;
    logic ctrl_wr;
    logic cont_wr;

    assign sel_ok   = !sel1_n && sel2 && !sel3_n;
    assign proc_hit = !strobe_proc_n && !sel1_n;
    assign any_hit  = proc_hit || !strobe_ctrl_n;
    assign wr_req   = !glob_wr_n || !byte_wr_n;
    assign ctrl_wr  = !strobe_ctrl_n && !proc_hit && sel_ok && wr_req;
    assign cont_wr  = selected && !any_hit && wr_req;

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R10
    write_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr || cont_wr) |=> !dq_oe);

    // R9
    desel_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        (any_hit && !sel_ok) |=> (!dq_oe && !selected));

    // R8
    reselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (any_hit && sel_ok && !selected) |=> !dq_oe);

    // R3
    proc_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe_proc_n && sel1_n && strobe_ctrl_n && !selected) |=> !selected);

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .sel1_n        (sel1_n),
    .sel2          (sel2),
    .sel3_n        (sel3_n),
    .glob_wr_n     (glob_wr_n),
    .byte_wr_n     (byte_wr_n),
    .oe_n          (oe_n),
    .dq_oe         (dq_oe),
    .selected      (selected)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  addr_i;
    logic        burst_order_i;
    logic        strobe_proc_n, strobe_ctrl_n, advance_n;
    logic        sel1_n, sel2, sel3_n;
    logic        glob_wr_n, byte_wr_n;
    logic [3:0]  lane_sel_n;
    logic        oe_n;
    logic [31:0] dq_i;
    logic [31:0] dq_o;
    logic        dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    burst_sram uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .burst_order_i(burst_order_i),
        .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
        .advance_n(advance_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
        .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic        gw_n;
        logic [3:0]  lanes_n;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 6'd4, 1'b0, 4'hF, 32'h11111111},
        '{1'b1, 6'd5, 1'b0, 4'hF, 32'h22222222},
        '{1'b1, 6'd6, 1'b0, 4'hF, 32'h33333333},
        '{1'b1, 6'd7, 1'b0, 4'hF, 32'h44444444},
        '{1'b0, 6'd4, 1'b1, 4'hF, 32'h0},
        '{1'b0, 6'd5, 1'b1, 4'hF, 32'h0},
        '{1'b0, 6'd6, 1'b1, 4'hF, 32'h0},
        '{1'b1, 6'd5, 1'b1, 4'hA, 32'hAABBCCDD},
        '{1'b1, 6'd6, 1'b0, 4'hE, 32'h55667788},
        '{1'b0, 6'd5, 1'b1, 4'hF, 32'h0},
        '{1'b0, 6'd6, 1'b1, 4'hF, 32'h0},
        '{1'b0, 6'd7, 1'b1, 4'hF, 32'h0},
        '{1'b0, 6'd4, 1'b1, 4'h0, 32'hDEADBEEF},
        '{1'b0, 6'd4, 1'b1, 4'hF, 32'h0}
    };

    logic [31:0] shadow [64];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; advance_n = 1'b1;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        glob_wr_n = 1'b1; byte_wr_n = 1'b1; lane_sel_n = 4'hF;
        oe_n = 1'b0; dq_i = 32'h0;
    endtask

    task automatic ctrl_access(input logic [5:0] a, input logic wr, input logic gw_n,
                               input logic [3:0] ln, input logic [31:0] d);
        idle();
        strobe_ctrl_n = 1'b0; addr_i = a; dq_i = d; lane_sel_n = ln;
        glob_wr_n = wr ? gw_n : 1'b1;
        byte_wr_n = wr ? 1'b0 : 1'b1;
        tick();
    endtask

    task automatic put(input logic [5:0] a, input logic [31:0] d);
        ctrl_access(a, 1'b1, 1'b0, 4'hF, d);
        shadow[a] = d;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic        prev_rd;
        logic [5:0]  prev_a;
        logic [3:0]  m;
        logic [31:0] old7;
        idle();
        addr_i = '0; burst_order_i = 1'b0;
        strobe_ctrl_n = 1'b1;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R13
        chk("R13 reset oe", {31'b0, dq_oe}, 32'd0);

        // table walk: R1 R2 R5 R6 R7 R10
        prev_rd = 1'b0; prev_a = '0;
        for (int i = 0; i < NV; i++) begin
            ctrl_access(TBL[i].addr, TBL[i].wr, TBL[i].gw_n, TBL[i].lanes_n, TBL[i].data);
            if (prev_rd) begin
                if (TBL[i].wr) begin
                    chk("R10 write tristate", {31'b0, dq_oe}, 32'd0);
                end else begin
                    chk("R1 read oe", {31'b0, dq_oe}, 32'd1);
                    chk("R1 R2 R6 R7 read data", dq_o, shadow[prev_a]);
                end
            end
            if (TBL[i].wr) begin
                m = (TBL[i].gw_n == 1'b0) ? 4'hF : ~TBL[i].lanes_n;
                for (int l = 0; l < 4; l++)
                    if (m[l]) shadow[TBL[i].addr][l*8 +: 8] = TBL[i].data[l*8 +: 8];
            end
            prev_rd = !TBL[i].wr;
            prev_a  = TBL[i].addr;
        end
        chk("R7 lane merge value", shadow[5], 32'h22BB22DD);

        // R11 asynchronous output enable
        ctrl_access(6'd4, 1'b0, 1'b1, 4'hF, 32'h0);
        idle(); tick();
        chk("R11 driving", {31'b0, dq_oe}, 32'd1);
        chk("R1 data", dq_o, 32'h11111111);
        #0.5 oe_n = 1'b1;
        #0.5 chk("R11 oe high", {31'b0, dq_oe}, 32'd0);
        oe_n = 1'b0;
        #0.5 chk("R11 oe low again", {31'b0, dq_oe}, 32'd1);

        // R9 deselect
        idle(); strobe_ctrl_n = 1'b0; sel2 = 1'b0; tick();
        chk("R9 deselect edge", {31'b0, dq_oe}, 32'd0);
        idle(); tick();
        chk("R9 stays off", {31'b0, dq_oe}, 32'd0);

        // R8 reselect
        ctrl_access(6'd6, 1'b0, 1'b1, 4'hF, 32'h0);
        chk("R8 first cycle", {31'b0, dq_oe}, 32'd0);
        idle(); tick();
        chk("R8 then oe", {31'b0, dq_oe}, 32'd1);
        chk("R8 data", dq_o, 32'h55667788);

        // R3 processor strobe masked while selected
        idle(); strobe_proc_n = 1'b0; sel1_n = 1'b1; addr_i = 6'd4; tick();
        idle(); tick();
        chk("R3 selected address kept", dq_o, 32'h55667788);
        // R3 while deselected
        idle(); strobe_ctrl_n = 1'b0; sel3_n = 1'b1; tick();
        idle(); strobe_proc_n = 1'b0; sel1_n = 1'b1; addr_i = 6'd4; tick();
        idle(); tick();
        chk("R3 no start", {31'b0, dq_oe}, 32'd0);

        // R4 processor-strobe write (from deselected)
        old7 = shadow[7];
        idle(); strobe_proc_n = 1'b0; addr_i = 6'd7; glob_wr_n = 1'b0;
        byte_wr_n = 1'b0; dq_i = 32'hEEEEEEEE; advance_n = 1'b0; tick();
        idle(); byte_wr_n = 1'b0; lane_sel_n = 4'hE; dq_i = 32'h000000A5; tick();
        chk("R4 R10 write cycle tristate", {31'b0, dq_oe}, 32'd0);
        ctrl_access(6'd7, 1'b0, 1'b1, 4'hF, 32'h0);
        idle(); tick();
        chk("R4 lane0 only", dq_o, {old7[31:8], 8'hA5});

        // R5 both strobes low: no controller write
        idle(); strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0; addr_i = 6'd4;
        glob_wr_n = 1'b0; dq_i = 32'h0BADF00D; tick();
        idle(); tick();
        chk("R5 read old", dq_o, 32'h11111111);
        idle(); tick();
        chk("R5 memory unchanged", dq_o, 32'h11111111);

        // R12 burst orders
        for (int k = 0; k < 4; k++) put(6'd8 + 6'(k), 32'h100 + k);
        for (int ord = 0; ord < 2; ord++) begin
            logic [1:0] off;
            idle(); strobe_ctrl_n = 1'b0; addr_i = 6'd9; burst_order_i = ord[0]; tick();
            burst_order_i = 1'b0;
            for (int k = 0; k < 4; k++) begin
                idle(); advance_n = (k == 3); tick();
                off = (ord == 1) ? (2'd1 ^ 2'(k)) : (2'd1 + 2'(k));
                chk("R12 burst word", dq_o, shadow[{4'd2, off}]);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule